// File: doc/BRIEF.md
# Exception Priority Arbiter

This block resolves which of a set of pending exceptions should be taken next. Three system exceptions carry fixed levels that sit above everything else: reset, the non-maskable interrupt and the hard fault. Three further system exceptions and nine external interrupt lines each carry a 2-bit level that software can set. The three further system exceptions are the supervisor call, the deferred service request and the system tick. Every cycle the arbiter compares all pending sources and registers the winner's exception number together with a valid flag.

Each source maps to a fixed exception number. The number space is sparse: some slots are reserved and have no source behind them. The arbiter only turns pending requests into a single choice. Comparison against the level of the handler that is currently running belongs to the surrounding logic, as do context saving and handler address lookup.

Top module: `exc_prio_arbiter`

## Requirements
- R1: After reset is released, `sel_valid` is 0 and `sel_num` is 0.
- R2: When no source is pending, `sel_valid` is 0 and `sel_num` is 0.
- R3: A pending reset (exception 1) is always selected, whatever the other inputs and the programmed levels are.
- R4: Without reset, a pending NMI (exception 2) beats every other source. Without reset and NMI, a pending hard fault (exception 3) beats every programmable source.
- R5: Among programmable sources, the numerically lowest programmed level wins.
- R6: When programmable sources share the best level, the lowest exception number wins.
- R7: All programmable levels are 0 after reset.
- R8: A cycle with `prio_wr_en`=1 loads `prio_wr_val` into the level slot `prio_wr_sel`. Slot 0 is the supervisor call, slot 1 the deferred service request, slot 2 the system tick, and slots 3..11 are external lines 0..8. Slot values 12..15 change nothing.
- R9: The exception numbers are fixed: supervisor call 11, deferred service request 14, system tick 15, and external line n is 16+n. Numbers 4..10, 12 and 13 are never output.
- R10: A change of the pending inputs shows at the outputs after one rising clock edge. A level write shows after two rising edges: one edge loads the level, the next registers the new choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pend_rst | input | 1 | Reset exception pending |
| pend_nmi | input | 1 | Non-maskable interrupt pending |
| pend_hflt | input | 1 | Hard fault pending |
| pend_svc | input | 1 | Supervisor call pending |
| pend_psv | input | 1 | Deferred service request pending |
| pend_tick | input | 1 | System tick pending |
| pend_irq | input | 9 | External interrupt lines 0..8 pending |
| prio_wr_en | input | 1 | Level write strobe |
| prio_wr_sel | input | 4 | Level slot to write (see R8) |
| prio_wr_val | input | 2 | Level value to write, 0 is most urgent |
| sel_valid | output | 1 | A source is selected |
| sel_num | output | 5 | Exception number of the selected source, 0 when none |

## Verification
The bench drives a new pending pattern half a cycle before a rising edge. It compares the outputs at the following falling edge, one edge later, because a single output register sits between the pending inputs and the result. A level write goes through two registers, the level slot and then the output register. For that reason the bench first checks that the old choice still stands after one edge, and checks for the new choice only after the second edge. A randomized sweep mixes writes and pending patterns, and each expected value comes from a reference built from the level and tie rules.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

  // Sources with a hard-wired level, in order of urgency.
  localparam int unsigned FIXED_SRCS    = 3;
  // System sources with a programmable level.
  localparam int unsigned SYS_PROG_SRCS = 3;

  localparam int unsigned EXC_RESET    = 1;
  localparam int unsigned EXC_NMI      = 2;
  localparam int unsigned EXC_HFLT     = 3;
  localparam int unsigned EXC_SVC      = 11;
  localparam int unsigned EXC_PSV      = 14;
  localparam int unsigned EXC_TICK     = 15;
  localparam int unsigned EXC_IRQ_BASE = 16;

  // Source index (ascending exception number) to exception number.
  function automatic int unsigned src_exc_num(int unsigned idx);
    case (idx)
      0:       return EXC_RESET;
      1:       return EXC_NMI;
      2:       return EXC_HFLT;
      3:       return EXC_SVC;
      4:       return EXC_PSV;
      5:       return EXC_TICK;
      default: return EXC_IRQ_BASE + idx - (FIXED_SRCS + SYS_PROG_SRCS);
    endcase
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/exc_prio_regs.sv
module exc_prio_regs #(
  parameter int unsigned NPROG  = 12,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned SEL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [PRIO_W-1:0]       wr_val,
  output logic [NPROG*PRIO_W-1:0] prio_flat
);

  for (genvar k = 0; k < NPROG; k++) begin : g_slot
    logic              slot_en;
    logic [PRIO_W-1:0] slot_d;
    logic [PRIO_W-1:0] slot_q;

    // Slot numbers at or above NPROG match no slot and are dropped.
    always_comb begin
      slot_en = wr_en && (wr_sel == SEL_W'(k));
      slot_d  = slot_en ? wr_val : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign prio_flat[k*PRIO_W +: PRIO_W] = slot_q;
  end

endmodule

// File: rtl/exc_src_key.sv
module exc_src_key
  import exc_arb_pkg::*;
#(
  parameter int unsigned NSRC   = 15,
  parameter int unsigned NPROG  = 12,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned NUM_W  = 5,
  localparam int unsigned KEY_W = 1 + LVL_W + NUM_W
) (
  input  logic [NSRC-1:0]         pend_vec,
  input  logic [NPROG*PRIO_W-1:0] prio_flat,
  output logic [NSRC*KEY_W-1:0]   key_flat
);

  // Key layout: {pending, level, exception number}; a smaller
  // {level, number} pair is more urgent.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [LVL_W-1:0] lvl;

    if (i < FIXED_SRCS) begin : g_fixed
      assign lvl = LVL_W'(i);
    end else begin : g_prog
      assign lvl = LVL_W'(FIXED_SRCS)
                 + LVL_W'(prio_flat[(i-FIXED_SRCS)*PRIO_W +: PRIO_W]);
    end

    assign key_flat[i*KEY_W +: KEY_W] = {pend_vec[i], lvl, NUM_W'(src_exc_num(i))};
  end

endmodule

// File: rtl/exc_min_tree.sv
module exc_min_tree #(
  parameter int unsigned N     = 15,
  parameter int unsigned KEY_W = 9
) (
  input  logic [N*KEY_W-1:0] key_flat,
  output logic [KEY_W-1:0]   win_key
);

  localparam int unsigned LEAVES = 1 << $clog2(N);
  localparam int unsigned NODES  = 2 * LEAVES - 1;
  localparam int unsigned RANK_W = KEY_W - 1;

  logic [KEY_W-1:0] node [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_used
      assign node[LEAVES-1+j] = key_flat[j*KEY_W +: KEY_W];
    end else begin : g_pad
      assign node[LEAVES-1+j] = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_cmp
    logic [KEY_W-1:0] lhs;
    logic [KEY_W-1:0] rhs;
    logic             take_lhs;

    assign lhs      = node[2*i+1];
    assign rhs      = node[2*i+2];
    assign take_lhs = lhs[KEY_W-1] &&
                      (!rhs[KEY_W-1] || (lhs[RANK_W-1:0] <= rhs[RANK_W-1:0]));
    assign node[i]  = take_lhs ? lhs : rhs;
  end

  assign win_key = node[0];

endmodule

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter
  import exc_arb_pkg::*;
#(
  parameter  int unsigned NUM_IRQ = 9,
  parameter  int unsigned PRIO_W  = 2,
  localparam int unsigned NPROG   = SYS_PROG_SRCS + NUM_IRQ,
  localparam int unsigned SEL_W   = $clog2(NPROG),
  localparam int unsigned NUM_W   = $clog2(EXC_IRQ_BASE + NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pend_rst,
  input  logic               pend_nmi,
  input  logic               pend_hflt,
  input  logic               pend_svc,
  input  logic               pend_psv,
  input  logic               pend_tick,
  input  logic [NUM_IRQ-1:0] pend_irq,
  input  logic               prio_wr_en,
  input  logic [SEL_W-1:0]   prio_wr_sel,
  input  logic [PRIO_W-1:0]  prio_wr_val,
  output logic               sel_valid,
  output logic [NUM_W-1:0]   sel_num
);

  localparam int unsigned NSRC  = FIXED_SRCS + NPROG;
  localparam int unsigned LVL_W = $clog2(FIXED_SRCS + (1 << PRIO_W));
  localparam int unsigned KEY_W = 1 + LVL_W + NUM_W;

  logic                    rst_core_n;
  logic [NSRC-1:0]         pend_vec;
  logic [NPROG*PRIO_W-1:0] prio_flat;
  logic [NSRC*KEY_W-1:0]   key_flat;
  logic [KEY_W-1:0]        win_key;

  logic                    nxt_valid;
  logic [NUM_W-1:0]        nxt_num;
  logic                    out_en;
  logic                    valid_q;
  logic [NUM_W-1:0]        num_q;

  exc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  exc_prio_regs #(
    .NPROG  (NPROG),
    .PRIO_W (PRIO_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (prio_wr_en),
    .wr_sel    (prio_wr_sel),
    .wr_val    (prio_wr_val),
    .prio_flat (prio_flat)
  );

  // Source order equals ascending exception number.
  assign pend_vec = {pend_irq, pend_tick, pend_psv, pend_svc,
                     pend_hflt, pend_nmi, pend_rst};

  exc_src_key #(
    .NSRC   (NSRC),
    .NPROG  (NPROG),
    .PRIO_W (PRIO_W),
    .LVL_W  (LVL_W),
    .NUM_W  (NUM_W)
  ) u_key (
    .pend_vec  (pend_vec),
    .prio_flat (prio_flat),
    .key_flat  (key_flat)
  );

  exc_min_tree #(
    .N     (NSRC),
    .KEY_W (KEY_W)
  ) u_tree (
    .key_flat (key_flat),
    .win_key  (win_key)
  );

  always_comb begin
    nxt_valid = win_key[KEY_W-1];
    nxt_num   = nxt_valid ? win_key[NUM_W-1:0] : '0;
    out_en    = (nxt_valid != valid_q) || (nxt_num != num_q);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else if (out_en) begin
      valid_q <= nxt_valid;
      num_q   <= nxt_num;
    end
  end

  assign sel_valid = valid_q;
  assign sel_num   = num_q;

endmodule

// File: rtl/exc_prio_arbiter_chk.sv
module exc_prio_arbiter_chk #(
  parameter int unsigned NUM_IRQ = 9,
  parameter int unsigned NUM_W   = 5
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               pend_rst,
  input logic               pend_nmi,
  input logic               pend_hflt,
  input logic               pend_svc,
  input logic               pend_psv,
  input logic               pend_tick,
  input logic [NUM_IRQ-1:0] pend_irq,
  input logic               sel_valid,
  input logic [NUM_W-1:0]   sel_num
);

  logic any_pend;
  logic num_legal;

  assign any_pend = pend_rst | pend_nmi | pend_hflt | pend_svc |
                    pend_psv | pend_tick | (|pend_irq);

  always_comb begin
    num_legal = (sel_num == NUM_W'(1)) || (sel_num == NUM_W'(2)) ||
                (sel_num == NUM_W'(3)) || (sel_num == NUM_W'(11)) ||
                (sel_num == NUM_W'(14)) || (sel_num == NUM_W'(15)) ||
                ((int'(sel_num) >= 16) && (int'(sel_num) < 16 + int'(NUM_IRQ)));
  end

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    !any_pend |=> (!sel_valid && (sel_num == '0)));

  a_r10_pend_valid: assert property (@(posedge clk) disable iff (!rst_core_n)
    any_pend |=> sel_valid);

  a_r3_reset_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    pend_rst |=> (sel_valid && (sel_num == NUM_W'(1))));

  a_r4_nmi_next: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!pend_rst && pend_nmi) |=> (sel_num == NUM_W'(2)));

  a_r4_hflt_next: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!pend_rst && !pend_nmi && pend_hflt) |=> (sel_num == NUM_W'(3)));

  a_r9_no_reserved: assert property (@(posedge clk) disable iff (!rst_core_n)
    sel_valid |-> num_legal);

endmodule

bind exc_prio_arbiter exc_prio_arbiter_chk #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_W   (NUM_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .pend_rst   (pend_rst),
  .pend_nmi   (pend_nmi),
  .pend_hflt  (pend_hflt),
  .pend_svc   (pend_svc),
  .pend_psv   (pend_psv),
  .pend_tick  (pend_tick),
  .pend_irq   (pend_irq),
  .sel_valid  (sel_valid),
  .sel_num    (sel_num)
);

// File: tb/exc_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module exc_prio_arbiter_tb_top;

  localparam int NUM_IRQ = 9;
  localparam int NPROG   = 12;
  localparam int NSRC    = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pend_rst, pend_nmi, pend_hflt, pend_svc, pend_psv, pend_tick;
  logic [8:0] pend_irq;
  logic       prio_wr_en;
  logic [3:0] prio_wr_sel;
  logic [1:0] prio_wr_val;
  logic       sel_valid;
  logic [4:0] sel_num;

  int checks = 0;
  int fails  = 0;
  logic [1:0]      mprio [NPROG];
  logic [NSRC-1:0] cur_pend;

  always #2.5 clk = ~clk;

  exc_prio_arbiter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_rst    (pend_rst),
    .pend_nmi    (pend_nmi),
    .pend_hflt   (pend_hflt),
    .pend_svc    (pend_svc),
    .pend_psv    (pend_psv),
    .pend_tick   (pend_tick),
    .pend_irq    (pend_irq),
    .prio_wr_en  (prio_wr_en),
    .prio_wr_sel (prio_wr_sel),
    .prio_wr_val (prio_wr_val),
    .sel_valid   (sel_valid),
    .sel_num     (sel_num)
  );

  function automatic int num_of(int idx);
    if (idx == 0) return 1;
    if (idx == 1) return 2;
    if (idx == 2) return 3;
    if (idx == 3) return 11;
    if (idx == 4) return 14;
    if (idx == 5) return 15;
    return 16 + idx - 6;
  endfunction

  // Reference choice built from the level and tie rules: {valid, number}.
  function automatic logic [5:0] ref_pick(logic [NSRC-1:0] p);
    for (int f = 0; f < 3; f++)
      if (p[f]) return {1'b1, 5'(num_of(f))};
    for (int lv = 0; lv < 4; lv++)
      for (int i = 3; i < NSRC; i++)
        if (p[i] && (int'(mprio[i-3]) == lv)) return {1'b1, 5'(num_of(i))};
    return 6'd0;
  endfunction

  task automatic check(string req, logic ev, logic [4:0] en);
    checks++;
    if (sel_valid !== ev || sel_num !== en) begin
      fails++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               req, sel_valid, sel_num, ev, en);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pend(logic [NSRC-1:0] p);
    cur_pend  = p;
    pend_rst  = p[0];
    pend_nmi  = p[1];
    pend_hflt = p[2];
    pend_svc  = p[3];
    pend_psv  = p[4];
    pend_tick = p[5];
    pend_irq  = p[14:6];
  endtask

  // Presents one write for a single edge; returns at the next falling edge.
  task automatic wr(int sel, int val);
    prio_wr_en  = 1'b1;
    prio_wr_sel = 4'(sel);
    prio_wr_val = 2'(val);
    tick(1);
    prio_wr_en  = 1'b0;
    if (sel < NPROG) mprio[sel] = 2'(val);
  endtask

  task automatic apply_and_check(string req, logic [NSRC-1:0] p);
    logic [5:0] e;
    set_pend(p);
    tick(1);
    e = ref_pick(p);
    check(req, e[5], e[4:0]);
  endtask

  task automatic t_reset_state;
    check("R1 reset state", 1'b0, 5'd0);
  endtask

  task automatic t_idle;
    set_pend('0);
    tick(1);
    check("R2 idle", 1'b0, 5'd0);
  endtask

  task automatic t_default_levels;
    // irq8 and system tick both at default level 0: tick (15) wins on number.
    set_pend(15'h4020);
    tick(1);
    check("R7 default level tie", 1'b1, 5'd15);
    set_pend(15'h7FC0);
    tick(1);
    check("R6 tie lowest irq", 1'b1, 5'd16);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < NPROG; k++) wr(k, 0);
    set_pend(15'h7FFF);
    tick(1);
    check("R3 reset over all", 1'b1, 5'd1);
    set_pend(15'h7FFE);
    tick(1);
    check("R4 nmi next", 1'b1, 5'd2);
    set_pend(15'h7FFC);
    tick(1);
    check("R4 hard fault next", 1'b1, 5'd3);
    set_pend(15'h0005);
    tick(1);
    check("R3 reset over hard fault", 1'b1, 5'd1);
  endtask

  task automatic t_prog_levels;
    for (int k = 0; k < NPROG; k++) wr(k, 3);
    wr(11, 0);                      // irq8 most urgent
    set_pend(15'h7FF8);
    tick(1);
    check("R5 lowest level wins", 1'b1, 5'd24);
    wr(0, 0);                       // svc ties at 0, lower number
    tick(1);
    check("R6 tie goes to svc", 1'b1, 5'd11);
    wr(0, 2);                       // svc now less urgent than irq8
    check("R10 write not yet visible", 1'b1, 5'd11);
    tick(1);
    check("R10 write visible after second edge", 1'b1, 5'd24);
  endtask

  task automatic t_ignored_slots;
    for (int k = 0; k < NPROG; k++) wr(k, 1);
    set_pend(15'h4020);
    tick(1);
    check("R8 baseline", 1'b1, 5'd15);
    for (int s = 12; s < 16; s++) wr(s, 0);
    tick(1);
    check("R8 slots 12..15 ignored", 1'b1, 5'd15);
    wr(11, 0);
    tick(1);
    check("R8 slot 11 is irq8", 1'b1, 5'd24);
  endtask

  task automatic t_mapping;
    for (int i = 0; i < NSRC; i++) begin
      set_pend(NSRC'(1) << i);
      tick(1);
      check("R9 number map", 1'b1, 5'(num_of(i)));
    end
  endtask

  task automatic t_latency;
    set_pend(15'h0010);             // deferred service request
    @(posedge clk);
    #1;
    check("R10 one edge", 1'b1, 5'd14);
    @(negedge clk);
  endtask

  task automatic t_sweep;
    for (int it = 0; it < 300; it++) begin
      logic [NSRC-1:0] p;
      p = NSRC'($urandom);
      if ($urandom_range(0, 3) != 0) p[2:0] = '0;
      if ($urandom_range(0, 2) == 0) wr($urandom_range(0, 15), $urandom_range(0, 3));
      apply_and_check("R5 R6 sweep", p);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL R10 watchdog: got hang, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5));
    for (int k = 0; k < NPROG; k++) mprio[k] = 2'd0;
    rst_n       = 1'b0;
    prio_wr_en  = 1'b0;
    prio_wr_sel = '0;
    prio_wr_val = '0;
    set_pend('0);
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset_state();
    t_idle();
    t_default_levels();
    t_fixed();
    t_prog_levels();
    t_ignored_slots();
    t_mapping();
    t_latency();
    t_sweep();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule